// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Decoder

This block sits on the inbound request path of a host-side bus port and separates interrupt messages from ordinary memory traffic. Each cycle it may see one request made of a valid bit, a write/read flag, a 64-bit byte address, a byte length and a 32-bit payload. A write whose address exactly matches the programmed doorbell address is an interrupt message. Its payload is taken as a vector number, and the output bit that belongs to that vector is inverted. A consumer detects an interrupt by watching for any change on that bit.

Reads that land in the 4-byte doorbell word are answered in the same cycle with zero data of the requested length. Every other request goes unchanged, in the same cycle, to a pass-through port that feeds the normal memory path. A doorbell write with the wrong length, or one that names a vector outside the owned window, raises a one-cycle error pulse and changes no output bit. The window is `NUM_VEC` vectors starting at `VEC_BASE`. The doorbell address is kept in a register that a configuration strobe loads.

Top module: `msi_doorbell_decoder`

## Requirements
- R1: After reset, `vec_toggle` is all zero, `msi_err` is 0, and the doorbell address equals `DB_RESET` with its two low bits cleared.
- R2: When `cfg_load` is high at a clock edge, the doorbell becomes `cfg_addr` with bits [1:0] forced to 0. The new value applies to requests from the next cycle on. A request in the same cycle as the load is decoded against the old value.
- R3: A write is an interrupt message only when `req_addr` equals the doorbell address in all 64 bits. Any other write, including one at an offset inside the doorbell word, appears on the pass-through port in the same cycle with address, length, data and direction unchanged, and it neither toggles a vector nor raises `msi_err`.
- R4: The payload is little-endian: `req_data[7:0]` is the byte at the lowest address, so the vector number n is `req_data` read as an unsigned 32-bit value. A message with length 4 and `VEC_BASE <= n < VEC_BASE+NUM_VEC` inverts `vec_toggle[n-VEC_BASE]` at the next clock edge and leaves every other bit unchanged.
- R5: A doorbell write whose `req_len` is not 4 sets `msi_err` high for the following cycle, leaves `vec_toggle` unchanged and is not passed through.
- R6: A doorbell write of length 4 whose vector n is below `VEC_BASE`, or at or above `VEC_BASE+NUM_VEC`, sets `msi_err` high for the following cycle, leaves `vec_toggle` unchanged and is not passed through.
- R7: A read whose address bits [63:2] match the doorbell address raises `rd_zero_valid` in the same cycle, with `rd_zero_len` equal to `req_len` and `rd_zero_data` equal to zero. It is not passed through. Reads elsewhere are passed through.
- R8: With `req_valid` low, `pass_valid` and `rd_zero_valid` are 0, and `vec_toggle` holds its value with `msi_err` 0 at the next edge.
- R9: Two messages to the same vector restore that bit to its earlier value, including when the two messages arrive on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Loads the doorbell register from cfg_addr |
| cfg_addr | input | 64 | New doorbell address |
| req_valid | input | 1 | Request present this cycle |
| req_is_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 64 | Request byte address |
| req_len | input | LEN_W | Request length in bytes |
| req_data | input | 32 | Write payload |
| pass_valid | output | 1 | Request forwarded to the memory path |
| pass_is_write | output | 1 | Forwarded direction |
| pass_addr | output | 64 | Forwarded address |
| pass_len | output | LEN_W | Forwarded length |
| pass_data | output | 32 | Forwarded payload |
| rd_zero_valid | output | 1 | Doorbell-word read answered here |
| rd_zero_len | output | LEN_W | Length of the zero response |
| rd_zero_data | output | 32 | Response data, always zero |
| vec_toggle | output | NUM_VEC | One toggle bit per owned vector |
| msi_err | output | 1 | One-cycle pulse for a malformed message |

## Verification
The bench builds the decoder with `NUM_VEC = 8` and `VEC_BASE = 40`. With these values a wrong offset between the vector number and the bit index shows up at once, and the values 39, 40, 47 and 48 probe both sides of both window edges. The doorbell is reprogrammed during the run to addresses with set low bits and a non-zero upper word, so the exact-match rule and the word-match rule for reads are tested against neighbours that differ in a single bit. A mixed pseudo-random phase interleaves messages, errors, reads, pass-through traffic and reloads.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;

    localparam int unsigned MSI_PAYLOAD_BYTES = 4;

    typedef enum logic [2:0] {
        REQ_IDLE    = 3'd0,
        REQ_PASS    = 3'd1,
        REQ_RD_ZERO = 3'd2,
        REQ_MSI_OK  = 3'd3,
        REQ_ERR_LEN = 3'd4,
        REQ_ERR_VEC = 3'd5
    } req_kind_e;

endpackage

// File: rtl/msi_db_addr_reg.sv
module msi_db_addr_reg #(
    parameter int unsigned      ADDR_W   = 64,
    parameter logic [63:0]      DB_RESET = 64'h0000_0000_FEE0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_addr,
    output logic [ADDR_W-1:0] db_addr
);

    localparam logic [ADDR_W-1:0] RESET_VAL = {DB_RESET[ADDR_W-1:2], 2'b00};

    typedef struct packed {
        logic [ADDR_W-1:0] db;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d.db = {cfg_addr[ADDR_W-1:2], 2'b00};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.db <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign db_addr = st_q.db;

endmodule

// File: rtl/msi_db_classify.sv
module msi_db_classify
    import msi_db_pkg::*;
#(
    parameter int unsigned ADDR_W   = 64,
    parameter int unsigned LEN_W    = 13,
    parameter int unsigned NUM_VEC  = 64,
    parameter int unsigned VEC_BASE = 0,
    parameter int unsigned IDX_W    = 6
) (
    input  logic              req_valid,
    input  logic              req_is_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [31:0]       req_data,
    input  logic [ADDR_W-1:0] db_addr,
    output req_kind_e         kind,
    output logic [IDX_W-1:0]  vec_idx
);

    localparam logic [32:0]      BASE_EXT = 33'(VEC_BASE);
    localparam logic [32:0]      SPAN_EXT = 33'(NUM_VEC);
    localparam logic [LEN_W-1:0] LEN_MSG  = LEN_W'(MSI_PAYLOAD_BYTES);

    logic [32:0] offset;
    logic        in_window;
    logic        addr_exact;
    logic        addr_word;

    always_comb begin
        // little-endian payload: req_data[7:0] is the lowest byte of n
        offset     = {1'b0, req_data} - BASE_EXT;
        in_window  = !offset[32] && (offset < SPAN_EXT);
        vec_idx    = offset[IDX_W-1:0];
        addr_exact = (req_addr == db_addr);
        addr_word  = (req_addr[ADDR_W-1:2] == db_addr[ADDR_W-1:2]);

        kind = REQ_IDLE;
        if (req_valid) begin
            if (req_is_write) begin
                if (!addr_exact)            kind = REQ_PASS;
                else if (req_len != LEN_MSG) kind = REQ_ERR_LEN;
                else if (!in_window)        kind = REQ_ERR_VEC;
                else                        kind = REQ_MSI_OK;
            end else begin
                kind = addr_word ? REQ_RD_ZERO : REQ_PASS;
            end
        end
    end

endmodule

// File: rtl/msi_db_toggle_bank.sv
module msi_db_toggle_bank #(
    parameter int unsigned NUM_VEC = 64,
    parameter int unsigned IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic               err_in,
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_VEC-1:0] vec_toggle,
    output logic               msi_err
);

    typedef struct packed {
        logic [NUM_VEC-1:0] tog;
        logic               err;
    } state_t;

    state_t             st_d, st_q;
    logic [NUM_VEC-1:0] flip;

    for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_flip
        assign flip[gi] = fire && (idx == IDX_W'(gi));
    end

    always_comb begin
        st_d     = st_q;
        st_d.tog = st_q.tog ^ flip;
        st_d.err = err_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_toggle = st_q.tog;
    assign msi_err    = st_q.err;

endmodule

// File: rtl/msi_doorbell_decoder.sv
module msi_doorbell_decoder
    import msi_db_pkg::*;
#(
    parameter int unsigned NUM_VEC  = 64,
    parameter int unsigned VEC_BASE = 0,
    parameter int unsigned LEN_W    = 13,
    parameter logic [63:0] DB_RESET = 64'h0000_0000_FEE0_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load,
    input  logic [63:0]        cfg_addr,
    input  logic               req_valid,
    input  logic               req_is_write,
    input  logic [63:0]        req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [31:0]        req_data,
    output logic               pass_valid,
    output logic               pass_is_write,
    output logic [63:0]        pass_addr,
    output logic [LEN_W-1:0]   pass_len,
    output logic [31:0]        pass_data,
    output logic               rd_zero_valid,
    output logic [LEN_W-1:0]   rd_zero_len,
    output logic [31:0]        rd_zero_data,
    output logic [NUM_VEC-1:0] vec_toggle,
    output logic               msi_err
);

    localparam int unsigned ADDR_W = 64;
    localparam int unsigned IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    logic [ADDR_W-1:0] db_addr;
    req_kind_e         kind;
    logic [IDX_W-1:0]  vec_idx;

    msi_db_addr_reg #(
        .ADDR_W   (ADDR_W),
        .DB_RESET (DB_RESET)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_addr (cfg_addr),
        .db_addr  (db_addr)
    );

    msi_db_classify #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .NUM_VEC  (NUM_VEC),
        .VEC_BASE (VEC_BASE),
        .IDX_W    (IDX_W)
    ) u_cls (
        .req_valid    (req_valid),
        .req_is_write (req_is_write),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .req_data     (req_data),
        .db_addr      (db_addr),
        .kind         (kind),
        .vec_idx      (vec_idx)
    );

    msi_db_toggle_bank #(
        .NUM_VEC (NUM_VEC),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (kind == REQ_MSI_OK),
        .err_in     ((kind == REQ_ERR_LEN) || (kind == REQ_ERR_VEC)),
        .idx        (vec_idx),
        .vec_toggle (vec_toggle),
        .msi_err    (msi_err)
    );

    assign pass_valid    = (kind == REQ_PASS);
    assign pass_is_write = req_is_write;
    assign pass_addr     = req_addr;
    assign pass_len      = req_len;
    assign pass_data     = req_data;

    assign rd_zero_valid = (kind == REQ_RD_ZERO);
    assign rd_zero_len   = req_len;
    assign rd_zero_data  = '0;

endmodule

// File: rtl/msi_doorbell_decoder_chk.sv
module msi_doorbell_decoder_chk #(
    parameter int unsigned NUM_VEC = 64,
    parameter int unsigned LEN_W   = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_load,
    input logic [63:0]        cfg_addr,
    input logic [63:0]        db_addr,
    input logic               req_valid,
    input logic               req_is_write,
    input logic [63:0]        req_addr,
    input logic [LEN_W-1:0]   req_len,
    input logic               pass_valid,
    input logic               rd_zero_valid,
    input logic [NUM_VEC-1:0] vec_toggle,
    input logic               msi_err
);

    a_r2_cfg_applies: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_load)) |-> (db_addr == {$past(cfg_addr[63:2]), 2'b00}));

    a_r4_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vec_toggle ^ $past(vec_toggle)) <= 1);

    a_r4_flip_needs_msg: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_toggle != $past(vec_toggle)) |->
        $past(req_valid && req_is_write && (req_addr == db_addr) && (req_len == LEN_W'(4))));

    a_r5_err_from_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
        msi_err |-> $past(req_valid && req_is_write && (req_addr == db_addr)));

    a_r6_err_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        msi_err |-> (vec_toggle == $past(vec_toggle)));

    a_r7_paths_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> (!rd_zero_valid && req_valid));

    a_r7_zero_only_reads: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero_valid |-> (req_valid && !req_is_write));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!pass_valid && !rd_zero_valid));

endmodule

bind msi_doorbell_decoder msi_doorbell_decoder_chk #(
    .NUM_VEC (NUM_VEC),
    .LEN_W   (LEN_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_load      (cfg_load),
    .cfg_addr      (cfg_addr),
    .db_addr       (db_addr),
    .req_valid     (req_valid),
    .req_is_write  (req_is_write),
    .req_addr      (req_addr),
    .req_len       (req_len),
    .pass_valid    (pass_valid),
    .rd_zero_valid (rd_zero_valid),
    .vec_toggle    (vec_toggle),
    .msi_err       (msi_err)
);

// File: tb/msi_doorbell_decoder_tb_top.sv
`timescale 1ns/1ps
module msi_doorbell_decoder_tb_top;

    localparam int unsigned NV    = 8;
    localparam int unsigned BASE  = 40;
    localparam int unsigned LW    = 13;
    localparam logic [63:0] DBR   = 64'h0000_0000_FEE0_0002;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [63:0]   cfg_addr = '0;
    logic          req_valid = 1'b0;
    logic          req_is_write = 1'b0;
    logic [63:0]   req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [31:0]   req_data = '0;
    logic          pass_valid, pass_is_write, rd_zero_valid, msi_err;
    logic [63:0]   pass_addr;
    logic [LW-1:0] pass_len, rd_zero_len;
    logic [31:0]   pass_data, rd_zero_data;
    logic [NV-1:0] vec_toggle;

    int errors = 0;
    int checks = 0;

    logic [NV-1:0] m_tog;
    logic          m_err;
    logic [63:0]   m_db;

    always #4 clk = ~clk;

    msi_doorbell_decoder #(
        .NUM_VEC (NV), .VEC_BASE (BASE), .LEN_W (LW), .DB_RESET (DBR)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_load (cfg_load), .cfg_addr (cfg_addr),
        .req_valid (req_valid), .req_is_write (req_is_write), .req_addr (req_addr),
        .req_len (req_len), .req_data (req_data),
        .pass_valid (pass_valid), .pass_is_write (pass_is_write), .pass_addr (pass_addr),
        .pass_len (pass_len), .pass_data (pass_data),
        .rd_zero_valid (rd_zero_valid), .rd_zero_len (rd_zero_len), .rd_zero_data (rd_zero_data),
        .vec_toggle (vec_toggle), .msi_err (msi_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    summary_and_finish: begin end

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One request cycle: drive, check same-cycle paths, step the model, check registered outputs.
    task automatic cycle(input string tag, input bit v, input bit w, input logic [63:0] a,
                         input int l, input logic [31:0] d,
                         input bit cl = 1'b0, input logic [63:0] ca = '0);
        bit exact, word, exp_pass, exp_zero;
        longint n;
        req_valid = v; req_is_write = w; req_addr = a; req_len = LW'(l); req_data = d;
        cfg_load = cl; cfg_addr = ca;
        #1;
        exact    = v && w && (a == m_db);
        word     = v && !w && (a[63:2] == m_db[63:2]);
        exp_pass = v && !exact && !word;
        exp_zero = word;
        chk("R3 pass_valid", 64'(pass_valid), 64'(exp_pass));
        if (exp_pass) begin
            chk("R3 pass fields", {pass_addr ^ a, 32'(pass_len) ^ 32'(l)} == '0 ? 64'd0 : 64'd1, 64'd0);
            chk("R3 pass data/dir", {31'd0, pass_is_write, pass_data}, {31'd0, w, d});
        end
        chk("R7 rd_zero_valid", 64'(rd_zero_valid), 64'(exp_zero));
        if (exp_zero) begin
            chk("R7 rd_zero_len", 64'(rd_zero_len), 64'(l));
            chk("R7 rd_zero_data", 64'(rd_zero_data), 64'd0);
        end
        @(posedge clk);
        n = longint'(d);
        m_err = 1'b0;
        if (exact) begin
            if (l != 4 || n < BASE || n >= BASE + NV) m_err = 1'b1;
            else m_tog[n - BASE] = ~m_tog[n - BASE];
        end
        if (cl) m_db = {ca[63:2], 2'b00};
        @(negedge clk);
        chk({tag, " vec_toggle"}, 64'(vec_toggle), 64'(m_tog));
        chk({tag, " msi_err"}, 64'(msi_err), 64'(m_err));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] db2;
        m_tog = '0; m_err = 1'b0; m_db = {DBR[63:2], 2'b00};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, doorbell reset value with low bits cleared
        chk("R1 vec_toggle", 64'(vec_toggle), 64'd0);
        chk("R1 msi_err", 64'(msi_err), 64'd0);
        cycle("R1", 1, 1, 64'hFEE0_0000, 4, 32'd40);
        chk("R1 bit0 set via reset doorbell", 64'(vec_toggle[0]), 64'd1);

        // R8: idle
        cycle("R8", 0, 1, 64'hFEE0_0000, 4, 32'd41);

        // R2: load with low bits set; same-cycle request uses old doorbell
        cycle("R2", 1, 1, 64'hFEE0_0000, 4, 32'd42, 1, 64'h0000_0001_FEE0_1003);
        cycle("R2", 1, 1, 64'hFEE0_0000, 4, 32'd43);
        cycle("R2", 1, 1, 64'h0000_0001_FEE0_1000, 4, 32'd43);

        // R4: window edges, little-endian value
        cycle("R4", 1, 1, m_db, 4, 32'd40);
        cycle("R4", 1, 1, m_db, 4, 32'd47);
        cycle("R4", 1, 1, m_db, 4, 32'h0000_002D);

        // R9: back-to-back on one vector
        cycle("R9", 1, 1, m_db, 4, 32'd44);
        cycle("R9", 1, 1, m_db, 4, 32'd44);
        chk("R9 bit4 restored", 64'(vec_toggle[4]), 64'd0);

        // R6: out of window
        cycle("R6", 1, 1, m_db, 4, 32'd39);
        cycle("R6", 1, 1, m_db, 4, 32'd48);
        cycle("R6", 1, 1, m_db, 4, 32'h2800_0000);
        cycle("R6", 0, 0, 64'd0, 0, 32'd0);

        // R5: bad lengths
        cycle("R5", 1, 1, m_db, 3, 32'd41);
        cycle("R5", 1, 1, m_db, 8, 32'd41);
        cycle("R5", 1, 1, m_db, 0, 32'd41);
        cycle("R5", 1, 1, m_db, 4, 32'd41);

        // R3: near misses pass through
        cycle("R3", 1, 1, m_db + 64'd1, 4, 32'd41);
        cycle("R3", 1, 1, m_db + 64'd4, 4, 32'd41);
        cycle("R3", 1, 1, {32'd0, m_db[31:0]}, 4, 32'd41);
        cycle("R3", 1, 1, m_db ^ 64'h8000_0000_0000_0000, 4, 32'd41);

        // R7: reads of the doorbell word and elsewhere
        cycle("R7", 1, 0, m_db, 4, 32'd0);
        cycle("R7", 1, 0, m_db + 64'd3, 1, 32'd0);
        cycle("R7", 1, 0, m_db + 64'd2, 64, 32'd0);
        cycle("R7", 1, 0, m_db + 64'd4, 4, 32'd0);

        // mixed traffic
        db2 = m_db;
        for (int i = 0; i < 400; i++) begin
            int sel, l;
            logic [63:0] a;
            logic [31:0] d;
            bit w, cl;
            logic [63:0] ca;
            sel = int'($urandom_range(0, 5));
            case (sel)
                0, 1, 2: a = m_db;
                3:       a = m_db + 64'($urandom_range(1, 7));
                4:       a = m_db ^ (64'd1 << $urandom_range(2, 63));
                default: a = {$urandom, $urandom};
            endcase
            l  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 9)) : 4;
            d  = 32'(BASE - 3 + $urandom_range(0, NV + 5));
            w  = ($urandom_range(0, 4) != 0);
            cl = ($urandom_range(0, 39) == 0);
            ca = cl ? (($urandom_range(0, 1) == 0) ? db2 : {32'($urandom_range(0, 3)), $urandom}) : 64'd0;
            cycle("R4", $urandom_range(0, 7) != 0, w, a, l, d, cl, ca);
        end

        finish_run();
    end

endmodule